// File: doc/BRIEF.md
# Banked DRAM Read Beat Buffer

This block sits between a two-bank DRAM array and a 72-bit system bus on the read side of a memory controller. Every DRAM read returns a 144-bit word. The block sends that word onto the bus as two back-to-back 72-bit beats. Each bank has its own 144-bit parking slot. Once a bank access has been committed, its data cannot be refused. So when the bus is held or busy on the cycle a word arrives, the word is parked in that bank's slot and sent later. When the bus is free and the arriving word is the next one due, it bypasses the slot and goes straight to the output register.

Reads are logged when they are issued. The log records the bank and the state of address bit 5. Words are always returned in issue order, whatever order the banks deliver them in. Address bit 5 picks which half of the word leaves first. One output selector chooses among three sources: the direct DRAM path, a parked slot, or a 72-bit register-read value. A register read is only given the bus when no memory read is outstanding.

Top module: `dram_read_beat_buffer`

## Requirements
- R1: After reset, `beat_valid` is 0 and `beat_src` is 2'b00 (no source) until a word or a register read is issued.
- R2: Each 144-bit word leaves as two beats on consecutive bus-free cycles, and the second beat has `beat_last`=1. With the issue-time address bit 5 at 0, bits [71:0] go first and bits [143:72] second. With it at 1, the order is reversed.
- R3: Fast path. Suppose a word arrives for the oldest outstanding read, with `bus_hold` and `bus_busy` both low and nothing parked for that bank. Its first beat then appears one clock later with `beat_src`=2'b01.
- R4: If `bus_hold` or `bus_busy` is high on the cycle a word arrives, the word is parked in its bank's slot. It is later delivered complete, with `beat_src`=2'b10.
- R5: A cycle with `bus_hold` or `bus_busy` high is followed by a cycle without a beat. A pending second half is kept and issued intact once the bus frees.
- R6: Words are returned in the order their reads were issued. A word that arrives for a bank that is not the oldest outstanding read is parked and produces no beat at that point.
- R7: With `csr_req` high, `csr_data` is issued as one beat with `beat_src`=2'b11 and `beat_last`=1. This happens only on a cycle when no memory read is outstanding. Otherwise the request waits.
- R8: Each bank has at most one outstanding read. A parked word is never overwritten, and DRAM data only arrives for a bank with an outstanding read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_issue | input | 1 | A read command is committed this cycle |
| rd_bank | input | 1 | Bank of the committed read |
| rd_addr5 | input | 1 | Address bit 5 of the read; 1 sends the upper half first |
| dram_valid | input | 1 | A DRAM word is valid this cycle |
| dram_bank | input | 1 | Bank that produced the DRAM word |
| dram_word | input | 144 | DRAM read word |
| bus_hold | input | 1 | Bus hold; stalls beat output |
| bus_busy | input | 1 | Bus busy; stalls beat output |
| csr_req | input | 1 | Register read data pending, held until served |
| csr_data | input | 72 | Register read data |
| beat_valid | output | 1 | A beat is on `beat_data` |
| beat_last | output | 1 | Final beat of a word or a register read |
| beat_src | output | 2 | 00 none, 01 direct DRAM, 10 parked slot, 11 register |
| beat_data | output | 72 | Bus beat |

## Verification
Assertions inside the design check several properties on every clock:
- a first beat is always followed by its last beat, from the same source;
- no beat follows a held or busy cycle;
- a register beat never goes out while a read is outstanding;
- a parked slot is never overwritten;
- no DRAM data arrives for a bank without an outstanding read.

Some behaviour can only be shown by the bench scenarios, because it depends on data values: that the half order follows address bit 5, that out-of-order bank returns come back in issue order, and that a stalled second half reappears unchanged.

// File: rtl/rbb_pkg.sv
package rbb_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_FAST = 2'b01,
        SRC_BUF  = 2'b10,
        SRC_CSR  = 2'b11
    } beat_src_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

endpackage

// File: rtl/rbb_order_fifo.sv
module rbb_order_fifo #(
    parameter int DEPTH = 2,
    parameter int IDW   = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [IDW-1:0] push_id,
    input  logic           pop,
    output logic           head_valid,
    output logic [IDW-1:0] head_id
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][IDW-1:0] ids;
        logic [PW-1:0]             rd;
        logic [PW-1:0]             wr;
        logic [CW-1:0]             cnt;
    } fifo_t;

    fifo_t q, d;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d = q;
        if (push) begin
            d.ids[q.wr] = push_id;
            d.wr        = step(q.wr);
        end
        if (pop) begin
            d.rd = step(q.rd);
        end
        d.cnt = q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign head_valid = (q.cnt != '0);
    assign head_id    = q.ids[q.rd];

    assert_log_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (q.cnt != CW'(DEPTH)));

    assert_log_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

endmodule

// File: rtl/rbb_slot.sv
module rbb_slot #(
    parameter int WORD_W = 144
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              issue_wrap,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    input  logic              take,
    output logic              outstanding,
    output logic              valid,
    output logic              wrap,
    output logic [WORD_W-1:0] data
);
    typedef struct packed {
        logic              pend;
        logic              full;
        logic              wrp;
        logic [WORD_W-1:0] word;
    } slot_t;

    slot_t q, d;

    always_comb begin
        d = q;
        if (issue) begin
            d.pend = 1'b1;
            d.wrp  = issue_wrap;
        end
        if (load) begin
            d.full = 1'b1;
            d.word = load_data;
        end
        if (take) begin
            d.pend = 1'b0;
            d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign outstanding = q.pend;
    assign valid       = q.full;
    assign wrap        = q.wrp;
    assign data        = q.word;

    assert_slot_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !q.full);

    assert_slot_single_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !q.pend);

    assert_slot_park_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> q.pend);

    assert_slot_take_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> q.pend);

endmodule

// File: rtl/rbb_out_ctrl.sv
module rbb_out_ctrl
    import rbb_pkg::*;
#(
    parameter int BEAT_W = 72,
    parameter int NBANK  = 2,
    parameter int IDW    = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            advance,
    input  logic                            head_valid,
    input  logic [IDW-1:0]                  head_id,
    input  logic [NBANK-1:0]                slot_valid,
    input  logic [NBANK-1:0]                slot_wrap,
    input  logic [NBANK-1:0][2*BEAT_W-1:0]  slot_data,
    input  logic                            dram_valid,
    input  logic [IDW-1:0]                  dram_bank,
    input  logic [2*BEAT_W-1:0]             dram_word,
    input  logic                            csr_req,
    input  logic [BEAT_W-1:0]               csr_data,
    output logic [NBANK-1:0]                take,
    output logic [NBANK-1:0]                park,
    output logic                            pop,
    output logic                            beat_valid,
    output logic                            beat_last,
    output logic [1:0]                      beat_src,
    output logic [BEAT_W-1:0]               beat_data
);
    localparam int WORD_W = 2 * BEAT_W;

    typedef struct packed {
        phase_e            ph;
        logic [BEAT_W-1:0] hold;
        beat_src_e         hsrc;
        logic              bv;
        logic              bl;
        beat_src_e         bs;
        logic [BEAT_W-1:0] bd;
    } oc_t;

    oc_t q, d;

    function automatic logic [BEAT_W-1:0] lead_half(input logic [WORD_W-1:0] w, input logic wr);
        return wr ? w[WORD_W-1:BEAT_W] : w[BEAT_W-1:0];
    endfunction

    function automatic logic [BEAT_W-1:0] tail_half(input logic [WORD_W-1:0] w, input logic wr);
        return wr ? w[BEAT_W-1:0] : w[WORD_W-1:BEAT_W];
    endfunction

    logic head_parked;
    logic head_arriving;

    always_comb begin
        head_parked   = head_valid && slot_valid[head_id];
        head_arriving = head_valid && dram_valid && (dram_bank == head_id) && !slot_valid[head_id];
    end

    always_comb begin
        d    = q;
        d.bv = 1'b0;
        d.bl = 1'b0;
        d.bs = SRC_NONE;
        take = '0;
        park = '0;
        pop  = 1'b0;
        if (dram_valid) begin
            park[dram_bank] = 1'b1;
        end
        if (advance) begin
            if (q.ph == PH_SECOND) begin
                d.bv = 1'b1;
                d.bl = 1'b1;
                d.bs = q.hsrc;
                d.bd = q.hold;
                d.ph = PH_FIRST;
            end else if (head_parked) begin
                d.bv          = 1'b1;
                d.bs          = SRC_BUF;
                d.bd          = lead_half(slot_data[head_id], slot_wrap[head_id]);
                d.hold        = tail_half(slot_data[head_id], slot_wrap[head_id]);
                d.hsrc        = SRC_BUF;
                d.ph          = PH_SECOND;
                take[head_id] = 1'b1;
                pop           = 1'b1;
            end else if (head_arriving) begin
                d.bv          = 1'b1;
                d.bs          = SRC_FAST;
                d.bd          = lead_half(dram_word, slot_wrap[head_id]);
                d.hold        = tail_half(dram_word, slot_wrap[head_id]);
                d.hsrc        = SRC_FAST;
                d.ph          = PH_SECOND;
                take[head_id] = 1'b1;
                park[head_id] = 1'b0;
                pop           = 1'b1;
            end else if (!head_valid && csr_req) begin
                d.bv = 1'b1;
                d.bl = 1'b1;
                d.bs = SRC_CSR;
                d.bd = csr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign beat_valid = q.bv;
    assign beat_last  = q.bl;
    assign beat_src   = q.bs;
    assign beat_data  = q.bd;

    assert_pair_completes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> (!beat_valid || (beat_last && beat_src == $past(beat_src))));

    assert_no_beat_after_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> !beat_valid);

    assert_csr_only_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_src == SRC_CSR) |-> $past(!head_valid));

    assert_idle_has_no_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |-> (beat_src == SRC_NONE));

endmodule

// File: rtl/dram_read_beat_buffer.sv
module dram_read_beat_buffer #(
    parameter int BEAT_W = 72,
    parameter int NBANK  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_issue,
    input  logic [((NBANK>1)?$clog2(NBANK):1)-1:0] rd_bank,
    input  logic                         rd_addr5,
    input  logic                         dram_valid,
    input  logic [((NBANK>1)?$clog2(NBANK):1)-1:0] dram_bank,
    input  logic [2*BEAT_W-1:0]          dram_word,
    input  logic                         bus_hold,
    input  logic                         bus_busy,
    input  logic                         csr_req,
    input  logic [BEAT_W-1:0]            csr_data,
    output logic                         beat_valid,
    output logic                         beat_last,
    output logic [1:0]                   beat_src,
    output logic [BEAT_W-1:0]            beat_data
);
    localparam int WORD_W = 2 * BEAT_W;
    localparam int IDW    = (NBANK > 1) ? $clog2(NBANK) : 1;

    logic                           advance;
    logic                           head_valid;
    logic [IDW-1:0]                 head_id;
    logic                           pop;
    logic [NBANK-1:0]               take;
    logic [NBANK-1:0]               park;
    logic [NBANK-1:0]               slot_pend;
    logic [NBANK-1:0]               slot_valid;
    logic [NBANK-1:0]               slot_wrap;
    logic [NBANK-1:0][WORD_W-1:0]   slot_data;

    assign advance = !bus_hold && !bus_busy;

    rbb_order_fifo #(
        .DEPTH (NBANK),
        .IDW   (IDW)
    ) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (rd_issue),
        .push_id    (rd_bank),
        .pop        (pop),
        .head_valid (head_valid),
        .head_id    (head_id)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        rbb_slot #(
            .WORD_W (WORD_W)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .issue       (rd_issue && (rd_bank == IDW'(b))),
            .issue_wrap  (rd_addr5),
            .load        (park[b]),
            .load_data   (dram_word),
            .take        (take[b]),
            .outstanding (slot_pend[b]),
            .valid       (slot_valid[b]),
            .wrap        (slot_wrap[b]),
            .data        (slot_data[b])
        );
    end

    rbb_out_ctrl #(
        .BEAT_W (BEAT_W),
        .NBANK  (NBANK),
        .IDW    (IDW)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .head_valid (head_valid),
        .head_id    (head_id),
        .slot_valid (slot_valid),
        .slot_wrap  (slot_wrap),
        .slot_data  (slot_data),
        .dram_valid (dram_valid),
        .dram_bank  (dram_bank),
        .dram_word  (dram_word),
        .csr_req    (csr_req),
        .csr_data   (csr_data),
        .take       (take),
        .park       (park),
        .pop        (pop),
        .beat_valid (beat_valid),
        .beat_last  (beat_last),
        .beat_src   (beat_src),
        .beat_data  (beat_data)
    );

    assert_data_has_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dram_valid |-> slot_pend[dram_bank]);

    assert_committed_not_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dram_valid |=> (slot_valid[$past(dram_bank)] || (beat_valid && !beat_last)));

endmodule

// File: tb/dram_read_beat_buffer_bench.sv
module dram_read_beat_buffer_bench;

    localparam int BW = 72;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rd_issue = 1'b0;
    logic [0:0]      rd_bank = '0;
    logic            rd_addr5 = 1'b0;
    logic            dram_valid = 1'b0;
    logic [0:0]      dram_bank = '0;
    logic [2*BW-1:0] dram_word = '0;
    logic            bus_hold = 1'b0;
    logic            bus_busy = 1'b0;
    logic            csr_req = 1'b0;
    logic [BW-1:0]   csr_data = '0;
    logic            beat_valid;
    logic            beat_last;
    logic [1:0]      beat_src;
    logic [BW-1:0]   beat_data;

    int tests_run = 0;
    int tests_failed = 0;

    always #5 clk = ~clk;

    dram_read_beat_buffer u_dram_read_beat_buffer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_issue   (rd_issue),
        .rd_bank    (rd_bank),
        .rd_addr5   (rd_addr5),
        .dram_valid (dram_valid),
        .dram_bank  (dram_bank),
        .dram_word  (dram_word),
        .bus_hold   (bus_hold),
        .bus_busy   (bus_busy),
        .csr_req    (csr_req),
        .csr_data   (csr_data),
        .beat_valid (beat_valid),
        .beat_last  (beat_last),
        .beat_src   (beat_src),
        .beat_data  (beat_data)
    );

    // {exp_src[1:0], use_busy, stall[1:0], bank, addr5, seed[11:0]}
    localparam logic [18:0] VEC [6] = '{
        {2'b01, 1'b0, 2'd0, 1'b0, 1'b0, 12'hA5C},
        {2'b01, 1'b0, 2'd0, 1'b1, 1'b1, 12'h3E1},
        {2'b10, 1'b0, 2'd2, 1'b0, 1'b1, 12'h777},
        {2'b10, 1'b1, 2'd1, 1'b1, 1'b0, 12'h0F0},
        {2'b10, 1'b0, 2'd3, 1'b1, 1'b1, 12'hC3A},
        {2'b01, 1'b0, 2'd0, 1'b0, 1'b1, 12'h19B}
    };

    function automatic logic [BW-1:0] hi_of(input logic [11:0] s);
        return {6{s}};
    endfunction

    function automatic logic [BW-1:0] lo_of(input logic [11:0] s);
        return ~{6{s}};
    endfunction

    task automatic check_beat(input logic [BW-1:0] ed, input logic [1:0] es,
                              input logic el, input string tag);
        tests_run++;
        if (!beat_valid || beat_data !== ed || beat_src !== es || beat_last !== el) begin
            tests_failed++;
            $display("FAIL %s: got v=%0b src=%0d last=%0b data=%h, expected v=1 src=%0d last=%0b data=%h",
                     tag, beat_valid, beat_src, beat_last, beat_data, es, el, ed);
        end
    endtask

    task automatic check_quiet(input string tag);
        tests_run++;
        if (beat_valid !== 1'b0) begin
            tests_failed++;
            $display("FAIL %s: got beat_valid=%0b src=%0d, expected beat_valid=0",
                     tag, beat_valid, beat_src);
        end
    endtask

    task automatic wait_beat();
        for (int i = 0; i < 30; i++) begin
            if (beat_valid) break;
            @(negedge clk);
        end
    endtask

    task automatic issue(input logic b, input logic a5);
        @(negedge clk);
        rd_issue = 1'b1;
        rd_bank  = b;
        rd_addr5 = a5;
        @(negedge clk);
        rd_issue = 1'b0;
    endtask

    task automatic run_vector(input logic [18:0] v);
        logic [1:0]  es;
        logic        busy;
        logic [1:0]  stall;
        logic        b;
        logic        a5;
        logic [11:0] s;
        {es, busy, stall, b, a5, s} = v;
        issue(b, a5);
        dram_valid = 1'b1;
        dram_bank  = b;
        dram_word  = {hi_of(s), lo_of(s)};
        if (stall != 0) begin
            if (busy) bus_busy = 1'b1;
            else      bus_hold = 1'b1;
        end
        @(negedge clk);
        dram_valid = 1'b0;
        if (stall != 0) begin
            check_quiet("R4 word parked, no beat while stalled");
            for (int k = 1; k < int'(stall); k++) begin
                @(negedge clk);
                check_quiet("R5 no beat during stall");
            end
            bus_hold = 1'b0;
            bus_busy = 1'b0;
            wait_beat();
        end
        check_beat(a5 ? hi_of(s) : lo_of(s), es, 1'b0,
                   (stall == 0) ? "R3 fast first beat" : "R4 parked first beat");
        @(negedge clk);
        check_beat(a5 ? lo_of(s) : hi_of(s), es, 1'b1, "R2 second beat order");
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tests_run++;
        if (beat_valid !== 1'b0 || beat_src !== 2'b00) begin
            tests_failed++;
            $display("FAIL R1 reset state: got v=%0b src=%0d, expected v=0 src=0",
                     beat_valid, beat_src);
        end

        foreach (VEC[i]) run_vector(VEC[i]);

        // R6: issue order b0 then b1, DRAM returns b1 first
        issue(1'b0, 1'b0);
        rd_issue = 1'b1; rd_bank = 1'b1; rd_addr5 = 1'b1;
        @(negedge clk);
        rd_issue = 1'b0;
        dram_valid = 1'b1; dram_bank = 1'b1; dram_word = {hi_of(12'h222), lo_of(12'h222)};
        @(negedge clk);
        check_quiet("R6 later bank parked without beat");
        dram_bank = 1'b0; dram_word = {hi_of(12'h111), lo_of(12'h111)};
        @(negedge clk);
        dram_valid = 1'b0;
        check_beat(lo_of(12'h111), 2'b01, 1'b0, "R6 oldest read first");
        @(negedge clk);
        check_beat(hi_of(12'h111), 2'b01, 1'b1, "R6 oldest read second");
        @(negedge clk);
        check_beat(hi_of(12'h222), 2'b10, 1'b0, "R6 parked bank first");
        @(negedge clk);
        check_beat(lo_of(12'h222), 2'b10, 1'b1, "R6 parked bank second");
        @(negedge clk);

        // R5: stall between the two beats
        issue(1'b0, 1'b0);
        dram_valid = 1'b1; dram_bank = 1'b0; dram_word = {hi_of(12'h5A5), lo_of(12'h5A5)};
        @(negedge clk);
        dram_valid = 1'b0;
        check_beat(lo_of(12'h5A5), 2'b01, 1'b0, "R5 first beat before stall");
        bus_hold = 1'b1;
        @(negedge clk);
        check_quiet("R5 second half held");
        @(negedge clk);
        check_quiet("R5 second half held");
        bus_hold = 1'b0;
        @(negedge clk);
        check_beat(hi_of(12'h5A5), 2'b01, 1'b1, "R5 second half after stall");
        @(negedge clk);

        // R7: register read waits for outstanding memory read
        issue(1'b1, 1'b0);
        csr_req = 1'b1; csr_data = 72'hCC_1234_5678_9ABC_DEF0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_quiet("R7 register read blocked by outstanding read");
        end
        dram_valid = 1'b1; dram_bank = 1'b1; dram_word = {hi_of(12'h3C3), lo_of(12'h3C3)};
        @(negedge clk);
        dram_valid = 1'b0;
        check_beat(lo_of(12'h3C3), 2'b01, 1'b0, "R7 memory beat before register");
        @(negedge clk);
        check_beat(hi_of(12'h3C3), 2'b01, 1'b1, "R7 memory second beat");
        @(negedge clk);
        check_beat(72'hCC_1234_5678_9ABC_DEF0, 2'b11, 1'b1, "R7 register beat after read");
        csr_req = 1'b0;
        @(negedge clk);
        check_quiet("R7 single register beat");

        // R7: register read on idle bus
        csr_req = 1'b1; csr_data = 72'h00_0F0F_F0F0_0F0F_F0F0;
        @(negedge clk);
        check_beat(72'h00_0F0F_F0F0_0F0F_F0F0, 2'b11, 1'b1, "R7 idle register beat");
        csr_req = 1'b0;
        @(negedge clk);
        check_quiet("R1 idle after register beat");

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule